// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block stores the four threshold offsets used by the flag comparators of a dual FIFO: an almost-empty offset and an almost-full offset for each of the two FIFOs. The offsets are set at configuration time. While the master reset is held, the two select pins either name one of three built-in offsets, which is then copied into all four registers, or request programming. A mode pin, also sampled during master reset, picks the programming method.

In serial programming the select pins take new roles after reset. One becomes a serial data line and the other a shift enable. A single chain of 40 bits runs through all four registers. In parallel programming, consecutive write strobes put the low bits of the port-A bus into the registers one after another. A done output goes high when the offsets are final. A partial reset never changes the offsets or the programming progress.

Top module: `flag_offset_loader`

## Requirements
- R1: On each clock edge while `mrst` is high, the code {`sel1_sen`,`sel0_sd`} is sampled. Code 01 loads 8, code 10 loads 16 and code 11 loads 64 into all four offsets, and `load_done` is high after that edge.
- R2: On each clock edge while `mrst` is high, code 00 clears all four offsets to 0 and drives `load_done` low. It also selects programming mode. `mode_serial` sampled at that edge chooses the method: 1 is serial, 0 is parallel.
- R3: In serial programming, each rising edge with `mrst` and `prst` low and `sel1_sen` high shifts `sel0_sd` into a 40-bit chain. The bits arrive MSB first in the order `ofs_ae1`, `ofs_af1`, `ofs_ae2`, `ofs_af2`. Each newly shifted bit enters bit 0 of `ofs_af2`, and every output shows the current chain contents.
- R4: In serial programming, `load_done` goes high after the edge that takes the 40th bit.
- R5: In parallel programming, each rising edge with `mrst` and `prst` low and `pwr_en` high writes `pdata` into the next offset, in the order `ofs_ae1`, `ofs_af1`, `ofs_ae2`, `ofs_af2`. `load_done` goes high after the fourth write.
- R6: Once `load_done` is high, later shifts and writes are ignored. The offsets and `load_done` hold until the next master reset.
- R7: After a master reset with a built-in code, activity on the select pins and on `pwr_en` has no effect.
- R8: In serial programming `pwr_en` is ignored. In parallel programming `sel1_sen` is ignored.
- R9: While `prst` is high, no shift or write is taken and the offsets and `load_done` are unchanged. Programming then continues from where it stopped.
- R10: A master reset during programming discards the partial progress and starts over with the newly sampled code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, active high; blocks loading |
| mode_serial | input | 1 | Programming method, sampled at master reset |
| sel0_sd | input | 1 | Select bit 0; serial data in serial mode |
| sel1_sen | input | 1 | Select bit 1; shift enable in serial mode |
| pwr_en | input | 1 | Parallel write strobe |
| pdata | input | OFS_W | Low bits of the port-A bus for parallel writes |
| ofs_ae1 | output | OFS_W | Almost-empty offset, FIFO 1 |
| ofs_af1 | output | OFS_W | Almost-full offset, FIFO 1 |
| ofs_ae2 | output | OFS_W | Almost-empty offset, FIFO 2 |
| ofs_af2 | output | OFS_W | Almost-full offset, FIFO 2 |
| load_done | output | 1 | All offsets final |

## Verification
The assertions check four rules on every cycle:
- the built-in value appears on all four outputs when a default-mode master reset ends;
- each shift event places the serial bit in the chain's last position;
- a partial reset freezes the offsets and the done flag;
- once done is high, the outputs and the flag stay frozen.

Only the bench scenarios can show the rest. These cover the exact bit and word ordering across the four registers, the 40-bit and four-write completion points, the cross-mode inputs being ignored, and a restart after an interrupted load.

// File: rtl/flo_pkg.sv
package flo_pkg;
  localparam int OFS_W   = 10;
  localparam int NUM_OFS = 4;

  typedef enum logic [1:0] {
    SEL_PROG = 2'b00,
    SEL_D8   = 2'b01,
    SEL_D16  = 2'b10,
    SEL_D64  = 2'b11
  } sel_code_e;

  // Built-in offset named by a select code; the programming code gives 0.
  function automatic int default_offset(input logic [1:0] code);
    case (code)
      SEL_D8:  return 8;
      SEL_D16: return 16;
      SEL_D64: return 64;
      default: return 0;
    endcase
  endfunction

  // Number of load events that complete programming.
  function automatic int load_events(input logic serial, input int w, input int n);
    return serial ? w * n : n;
  endfunction
endpackage

// File: rtl/flo_cfg.sv
module flo_cfg
  import flo_pkg::*;
#(
  parameter int OFS_W = flo_pkg::OFS_W
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic [1:0]       sel_code,
  input  logic             mode_in,
  output logic [OFS_W-1:0] init_val,
  output logic             init_done,
  output logic             prog_mode,
  output logic             serial_mode,
  output logic [OFS_W-1:0] dflt_val
);
  always_comb begin
    init_val  = OFS_W'(default_offset(sel_code));
    init_done = (sel_code != SEL_PROG);
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      prog_mode   <= (sel_code == SEL_PROG);
      serial_mode <= mode_in;
      dflt_val    <= init_val;
    end
  end
endmodule

// File: rtl/flo_seq.sv
module flo_seq
  import flo_pkg::*;
#(
  parameter int OFS_W   = flo_pkg::OFS_W,
  parameter int NUM_OFS = flo_pkg::NUM_OFS,
  localparam int SER_LAST = OFS_W * NUM_OFS,
  localparam int CNT_W    = $clog2(SER_LAST + 1),
  localparam int IDX_W    = (NUM_OFS > 1) ? $clog2(NUM_OFS) : 1
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prst,
  input  logic             init_done,
  input  logic             prog_mode,
  input  logic             serial_mode,
  input  logic             sen,
  input  logic             pwr_en,
  output logic             shift_ev,
  output logic             wr_ev,
  output logic [IDX_W-1:0] wr_idx,
  output logic             load_done
);
  logic [CNT_W-1:0] cnt_q;
  logic             active;
  logic             final_ev;

  always_comb begin
    active   = !mrst && !prst && prog_mode && !load_done;
    shift_ev = active && serial_mode && sen;
    wr_ev    = active && !serial_mode && pwr_en;
    final_ev = (shift_ev || wr_ev) &&
               (cnt_q == CNT_W'(load_events(serial_mode, OFS_W, NUM_OFS) - 1));
    wr_idx   = cnt_q[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      cnt_q     <= '0;
      load_done <= init_done;
    end else if (shift_ev || wr_ev) begin
      cnt_q <= cnt_q + 1'b1;
      if (final_ev) load_done <= 1'b1;
    end
  end
endmodule

// File: rtl/flo_store.sv
module flo_store
  import flo_pkg::*;
#(
  parameter int OFS_W   = flo_pkg::OFS_W,
  parameter int NUM_OFS = flo_pkg::NUM_OFS,
  localparam int IDX_W  = (NUM_OFS > 1) ? $clog2(NUM_OFS) : 1
) (
  input  logic                     clk,
  input  logic                     init_en,
  input  logic [OFS_W-1:0]         init_val,
  input  logic                     shift_en,
  input  logic                     sdata,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [OFS_W-1:0]         wr_val,
  output logic [NUM_OFS*OFS_W-1:0] ofs_vec
);
  logic [OFS_W-1:0]   ofs_r [NUM_OFS];
  logic [NUM_OFS-1:0] carry_in;

  // Chain: register 0 is first in order; new bits enter the last register.
  for (genvar g = 0; g < NUM_OFS; g++) begin : g_chain
    if (g == NUM_OFS - 1) begin : g_tail
      assign carry_in[g] = sdata;
    end else begin : g_link
      assign carry_in[g] = ofs_r[g+1][OFS_W-1];
    end
    assign ofs_vec[g*OFS_W +: OFS_W] = ofs_r[g];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_OFS; i++) begin
      if (init_en)
        ofs_r[i] <= init_val;
      else if (shift_en)
        ofs_r[i] <= {ofs_r[i][OFS_W-2:0], carry_in[i]};
      else if (wr_en && wr_idx == IDX_W'(i))
        ofs_r[i] <= wr_val;
    end
  end
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import flo_pkg::*;
#(
  parameter int OFS_W = flo_pkg::OFS_W
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prst,
  input  logic             mode_serial,
  input  logic             sel0_sd,
  input  logic             sel1_sen,
  input  logic             pwr_en,
  input  logic [OFS_W-1:0] pdata,
  output logic [OFS_W-1:0] ofs_ae1,
  output logic [OFS_W-1:0] ofs_af1,
  output logic [OFS_W-1:0] ofs_ae2,
  output logic [OFS_W-1:0] ofs_af2,
  output logic             load_done
);
  localparam int NUM_OFS = 4;
  localparam int IDX_W   = $clog2(NUM_OFS);

  logic [OFS_W-1:0]         init_val;
  logic                     init_done;
  logic                     prog_mode;
  logic                     serial_mode;
  logic [OFS_W-1:0]         dflt_val;
  logic                     shift_ev;
  logic                     wr_ev;
  logic [IDX_W-1:0]         wr_idx;
  logic [NUM_OFS*OFS_W-1:0] ofs_vec;

  flo_cfg #(.OFS_W(OFS_W)) u_cfg (
    .clk        (clk),
    .mrst       (mrst),
    .sel_code   ({sel1_sen, sel0_sd}),
    .mode_in    (mode_serial),
    .init_val   (init_val),
    .init_done  (init_done),
    .prog_mode  (prog_mode),
    .serial_mode(serial_mode),
    .dflt_val   (dflt_val)
  );

  flo_seq #(.OFS_W(OFS_W), .NUM_OFS(NUM_OFS)) u_seq (
    .clk        (clk),
    .mrst       (mrst),
    .prst       (prst),
    .init_done  (init_done),
    .prog_mode  (prog_mode),
    .serial_mode(serial_mode),
    .sen        (sel1_sen),
    .pwr_en     (pwr_en),
    .shift_ev   (shift_ev),
    .wr_ev      (wr_ev),
    .wr_idx     (wr_idx),
    .load_done  (load_done)
  );

  flo_store #(.OFS_W(OFS_W), .NUM_OFS(NUM_OFS)) u_store (
    .clk     (clk),
    .init_en (mrst),
    .init_val(init_val),
    .shift_en(shift_ev),
    .sdata   (sel0_sd),
    .wr_en   (wr_ev),
    .wr_idx  (wr_idx),
    .wr_val  (pdata),
    .ofs_vec (ofs_vec)
  );

  assign ofs_ae1 = ofs_vec[0*OFS_W +: OFS_W];
  assign ofs_af1 = ofs_vec[1*OFS_W +: OFS_W];
  assign ofs_ae2 = ofs_vec[2*OFS_W +: OFS_W];
  assign ofs_af2 = ofs_vec[3*OFS_W +: OFS_W];
endmodule

// File: rtl/flo_checker.sv
module flo_checker #(
  parameter int OFS_W = 10
) (
  input logic             clk,
  input logic             mrst,
  input logic             prst,
  input logic             sel0_sd,
  input logic             shift_ev,
  input logic             prog_mode,
  input logic [OFS_W-1:0] dflt_val,
  input logic [OFS_W-1:0] ofs_ae1,
  input logic [OFS_W-1:0] ofs_af1,
  input logic [OFS_W-1:0] ofs_ae2,
  input logic [OFS_W-1:0] ofs_af2,
  input logic             load_done
);
  assert_default_load_R1: assert property (@(posedge clk) disable iff (mrst)
    ($fell(mrst) && !prog_mode) |->
      (ofs_ae1 == dflt_val && ofs_af1 == dflt_val &&
       ofs_ae2 == dflt_val && ofs_af2 == dflt_val && load_done));

  assert_shift_tail_R3: assert property (@(posedge clk) disable iff (mrst)
    shift_ev |=> (ofs_af2[0] == $past(sel0_sd)));

  assert_done_freeze_R6: assert property (@(posedge clk) disable iff (mrst)
    load_done |=> (load_done && $stable(ofs_ae1) && $stable(ofs_af1) &&
                   $stable(ofs_ae2) && $stable(ofs_af2)));

  assert_partial_hold_R9: assert property (@(posedge clk) disable iff (mrst)
    prst |=> ($stable(load_done) && $stable(ofs_ae1) && $stable(ofs_af1) &&
              $stable(ofs_ae2) && $stable(ofs_af2)));
endmodule

bind flag_offset_loader flo_checker #(.OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .mrst     (mrst),
  .prst     (prst),
  .sel0_sd  (sel0_sd),
  .shift_ev (shift_ev),
  .prog_mode(prog_mode),
  .dflt_val (dflt_val),
  .ofs_ae1  (ofs_ae1),
  .ofs_af1  (ofs_af1),
  .ofs_ae2  (ofs_ae2),
  .ofs_af2  (ofs_af2),
  .load_done(load_done)
);

// File: tb/sim_flag_offset_loader.sv
`timescale 1ns/1ps
module sim_flag_offset_loader;
  logic       clk = 1'b0;
  logic       mrst = 1'b1, prst = 1'b0, mode_serial = 1'b0;
  logic       sel0_sd = 1'b1, sel1_sen = 1'b0, pwr_en = 1'b0;
  logic [9:0] pdata = '0;
  logic [9:0] ofs_ae1, ofs_af1, ofs_ae2, ofs_af2;
  logic       load_done;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  flag_offset_loader u0 (
    .clk(clk), .mrst(mrst), .prst(prst), .mode_serial(mode_serial),
    .sel0_sd(sel0_sd), .sel1_sen(sel1_sen), .pwr_en(pwr_en), .pdata(pdata),
    .ofs_ae1(ofs_ae1), .ofs_af1(ofs_af1), .ofs_ae2(ofs_ae2), .ofs_af2(ofs_af2),
    .load_done(load_done)
  );

  // Behavioural reference model
  int  m_ofs [4];
  int  m_cnt;
  bit  m_prog, m_ser, m_done, m_valid = 0;

  always @(posedge clk) begin
    int code;
    if (mrst) begin
      code    = {sel1_sen, sel0_sd};
      m_prog  = (code == 0);
      m_ser   = mode_serial;
      for (int i = 0; i < 4; i++)
        m_ofs[i] = (code == 1) ? 8 : (code == 2) ? 16 : (code == 3) ? 64 : 0;
      m_cnt   = 0;
      m_done  = !m_prog;
      m_valid = 1;
    end else if (!prst && m_prog && !m_done) begin
      if (m_ser && sel1_sen) begin
        for (int i = 0; i < 3; i++)
          m_ofs[i] = ((m_ofs[i] << 1) | (m_ofs[i+1] >> 9)) & 1023;
        m_ofs[3] = ((m_ofs[3] << 1) | int'(sel0_sd)) & 1023;
        m_cnt++;
        if (m_cnt == 40) m_done = 1;
      end else if (!m_ser && pwr_en) begin
        m_ofs[m_cnt] = int'(pdata);
        m_cnt++;
        if (m_cnt == 4) m_done = 1;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (m_valid && !finished) begin
      check({cur_req, " ae1"}, int'(ofs_ae1), m_ofs[0]);
      check({cur_req, " af1"}, int'(ofs_af1), m_ofs[1]);
      check({cur_req, " ae2"}, int'(ofs_ae2), m_ofs[2]);
      check({cur_req, " af2"}, int'(ofs_af2), m_ofs[3]);
      check({cur_req, " done"}, int'(load_done), int'(m_done));
    end
  end

  task automatic do_mrst(input logic [1:0] code, input logic ser);
    @(negedge clk);
    mrst = 1; {sel1_sen, sel0_sd} = code; mode_serial = ser; pwr_en = 0; prst = 0;
    @(negedge clk);
    @(negedge clk);
    mrst = 0; sel1_sen = 0; sel0_sd = 0;
  endtask

  task automatic expect_all(string req, int a, int b, int c, int d, int dn);
    check(req, int'(ofs_ae1), a);
    check(req, int'(ofs_af1), b);
    check(req, int'(ofs_ae2), c);
    check(req, int'(ofs_af2), d);
    check(req, int'(load_done), dn);
  endtask

  // Shift one 10-bit word MSB first; gap inserts an idle cycle after each bit
  task automatic shift_word(input logic [9:0] v, input bit gap);
    for (int b = 9; b >= 0; b--) begin
      @(negedge clk); sel0_sd = v[b]; sel1_sen = 1;
      if (gap) begin @(negedge clk); sel1_sen = 0; sel0_sd = ~v[b]; end
    end
    @(negedge clk); sel1_sen = 0;
  endtask

  task automatic pwrite(input logic [9:0] v);
    @(negedge clk); pdata = v; pwr_en = 1;
    @(negedge clk); pwr_en = 0; pdata = ~v;
  endtask

  initial begin
    // R1: built-in offsets
    cur_req = "R1";
    do_mrst(2'b01, 0); expect_all("R1 code01", 8, 8, 8, 8, 1);
    // R7: pins ignored in default mode
    cur_req = "R7";
    repeat (6) begin
      @(negedge clk); sel0_sd = ~sel0_sd; sel1_sen = 1; pwr_en = 1; pdata = 10'h3A5;
    end
    @(negedge clk); sel1_sen = 0; pwr_en = 0;
    @(negedge clk); expect_all("R7 ignored", 8, 8, 8, 8, 1);
    cur_req = "R1";
    do_mrst(2'b10, 1); expect_all("R1 code10", 16, 16, 16, 16, 1);
    do_mrst(2'b11, 0); expect_all("R1 code11", 64, 64, 64, 64, 1);

    // R2/R3/R4/R9/R8: serial programming
    cur_req = "R2";
    do_mrst(2'b00, 1); expect_all("R2 prog clear", 0, 0, 0, 0, 0);
    cur_req = "R3";
    shift_word(10'h2C7, 0);
    shift_word(10'h155, 1);
    cur_req = "R9";
    @(negedge clk); prst = 1; sel1_sen = 1; sel0_sd = 1;
    repeat (3) @(negedge clk);
    prst = 0; sel1_sen = 0;
    cur_req = "R8";
    @(negedge clk); pwr_en = 1; pdata = 10'h3FF;
    @(negedge clk); pwr_en = 0;
    cur_req = "R3";
    shift_word(10'h00F, 0);
    @(negedge clk); check("R4 not yet done", int'(load_done), 0);
    shift_word(10'h301, 0);
    @(negedge clk); expect_all("R3 R4 serial final", 'h2C7, 'h155, 'h00F, 'h301, 1);
    cur_req = "R6";
    shift_word(10'h3FF, 0);
    @(negedge clk); expect_all("R6 serial hold", 'h2C7, 'h155, 'h00F, 'h301, 1);

    // R5/R8/R9/R6: parallel programming
    cur_req = "R5";
    do_mrst(2'b00, 0); expect_all("R2 parallel clear", 0, 0, 0, 0, 0);
    pwrite(10'h111);
    cur_req = "R8";
    repeat (4) begin @(negedge clk); sel1_sen = 1; sel0_sd = 1; end
    @(negedge clk); sel1_sen = 0;
    check("R8 sen ignored", int'(ofs_af1), 0);
    cur_req = "R9";
    @(negedge clk); prst = 1; pwr_en = 1; pdata = 10'h0AA;
    @(negedge clk); pwr_en = 0;
    @(negedge clk); prst = 0;
    check("R9 write blocked", int'(ofs_af1), 0);
    cur_req = "R5";
    pwrite(10'h222); pwrite(10'h333);
    check("R5 not yet done", int'(load_done), 0);
    pwrite(10'h044);
    expect_all("R5 parallel final", 'h111, 'h222, 'h333, 'h044, 1);
    cur_req = "R6";
    pwrite(10'h3C3);
    expect_all("R6 parallel hold", 'h111, 'h222, 'h333, 'h044, 1);

    // R10: restart mid programming
    cur_req = "R10";
    do_mrst(2'b00, 0);
    pwrite(10'h1F0); pwrite(10'h0F1);
    do_mrst(2'b00, 1);
    expect_all("R10 restart clear", 0, 0, 0, 0, 0);
    shift_word(10'h001, 0); shift_word(10'h002, 0);
    shift_word(10'h004, 0); shift_word(10'h008, 0);
    @(negedge clk); expect_all("R10 restart serial", 1, 2, 4, 8, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule